// File: doc/BRIEF.md
# Receive Packet Collector with Commit and Rollback

This block sits behind the receive side of a serial-link transaction core, on one virtual channel, and gathers each incoming transaction packet into a local word buffer. A start strobe marks the first word and an end strobe marks the last. Every word in between arrives on consecutive clocks. The words go into the buffer as they arrive, but they stay pending. The reader cannot see them until the final beat shows the packet is clean. At that point the write position is committed. If the packet is bad, the write position is wound back to where the packet began.

Error information is sampled only on the final beat. That covers the end-to-end CRC failure flag and the length-problem flag. Two more faults are raised by the collector itself. The first is a start strobe arriving while a packet is still open, which is a framing fault. The second is the buffer running out of space in the middle of a packet, which is an overflow. For every packet that closes, whether committed or thrown away, a status word is presented for one cycle. It carries the word count and four fault bits.

Committed words leave through a simple valid/ready read port, oldest first. They are followed by the next packet's words only once that packet has committed.

Top module: `rxpkt_collector`

## Requirements
- R1: While reset is held, `out_valid` and `stat_valid` are both 0.
- R2: A clean packet of N words (N no larger than the buffer depth) is stored in arrival order. After its final beat, all N words can be read in that order at `out_data` while `out_valid` is 1, advancing one word per cycle with `out_ready` high.
- R3: The clock edge that captures a final beat raises `stat_valid` for exactly one cycle. `stat_len` then holds the number of words in the packet, counting the start word.
- R4: A CRC error flag on the final beat discards the whole packet (nothing becomes readable) and sets `stat_ecrc`.
- R5: CRC error and length-problem flags on any beat other than the final one have no effect: the packet commits and its status fault bits are all 0.
- R6: A length-problem flag on the final beat discards the whole packet and sets `stat_malf`.
- R7: A start strobe while a packet is open discards the open packet. A status appears on the next cycle with `stat_frame` set and `stat_len` equal to the open packet's word count. The strobed word becomes the first word of a new packet.
- R8: A beat carrying both start and end strobes while a packet is open discards both packets. It produces a single framing status with the open packet's word count.
- R9: The buffer holds DEPTH words, counting committed-but-unread words and pending ones. A word that arrives while DEPTH words are held at the start of that cycle causes the packet to be discarded. Its status has `stat_ovf` set and `stat_len` equal to the full word count of the packet. Earlier committed words are unaffected.
- R10: Beats without a start strobe while no packet is open are ignored: no status, nothing stored.
- R11: The words of a packet still in progress are never visible on the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| rx_sop | input | 1 | First word of a packet is on `rx_data` |
| rx_eop | input | 1 | Final word of a packet is on `rx_data` |
| rx_data | input | DATA_W | Packet word |
| rx_ecrc_err | input | 1 | End-to-end CRC failure, meaningful on the final beat |
| rx_malformed | input | 1 | Length problem, meaningful on the final beat |
| out_valid | output | 1 | A committed word is available |
| out_ready | input | 1 | Consumer takes the word at `out_data` |
| out_data | output | DATA_W | Oldest committed word |
| stat_valid | output | 1 | One-cycle status strobe per closed packet |
| stat_len | output | LEN_W | Words received in the closed packet |
| stat_ecrc | output | 1 | Packet closed with a CRC failure |
| stat_malf | output | 1 | Packet closed with a length problem |
| stat_frame | output | 1 | Packet cut short by a new start strobe |
| stat_ovf | output | 1 | Packet lost to lack of buffer space |

## Verification
The hardest corner is the exact fill boundary. The bench sweeps every amount of already-committed unread data against every packet length in a small buffer. A collector that mis-counts space by one would either commit a packet that should overflow, or wrongly drop one that fits exactly. A pointer that is wound back to the wrong place would corrupt the earlier packet's words. A second corner is a start strobe inside an open packet, with and without a simultaneous end strobe. A wrong design would leak the old words, lose the new packet's first word, or emit two statuses. Flags on non-final beats and strobes outside any packet are driven to catch a design that samples errors too early, or that opens a packet without a start.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  // Fault bits reported with every closed packet.
  typedef struct packed {
    logic ecrc;
    logic malf;
    logic frame;
    logic ovf;
  } rxc_flags_t;

  localparam rxc_flags_t RXC_NO_FAULT = '{ecrc: 1'b0, malf: 1'b0, frame: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/rxc_rst_sync.sv
module rxc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/rxc_frame_ctrl.sv
module rxc_frame_ctrl
  import rxc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             eop,
  input  logic             ecrc_err,
  input  logic             malformed,
  input  logic             full_wr,
  input  logic             full_base,
  output logic             wr_en,
  output logic             commit,
  output logic             discard,
  output logic             sts_fire,
  output logic [LEN_W-1:0] sts_len,
  output rxc_flags_t       sts_flags
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             open_q, open_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ovf_q, ovf_d;

  logic             active;
  logic             abort;
  logic             room;
  logic             cur_ovf;
  logic             wr_ok;
  logic             new_ovf;
  logic             pkt_end;
  logic             end_bad;
  logic [LEN_W-1:0] cur_len;

  // Next-state and command decode
  always_comb begin
    active  = sop | open_q;
    abort   = sop & open_q;
    // a restarted packet writes from the committed position
    room    = abort ? ~full_base : ~full_wr;
    cur_ovf = sop ? 1'b0 : ovf_q;
    wr_ok   = active & room & ~cur_ovf;
    new_ovf = active & ~(room & ~cur_ovf);
    cur_len = (sop ? {LEN_W{1'b0}} : len_q) + ONE;
    pkt_end = active & eop;
    end_bad = pkt_end & (ecrc_err | malformed | abort | ~wr_ok);

    wr_en   = wr_ok & ~end_bad;
    commit  = pkt_end & ~end_bad;
    discard = abort | end_bad;

    open_d  = active & ~eop;
    len_d   = active ? cur_len : len_q;
    ovf_d   = active ? new_ovf : ovf_q;

    sts_fire = abort | pkt_end;
    if (abort) begin
      sts_len   = len_q;
      sts_flags = '{ecrc: 1'b0, malf: 1'b0, frame: 1'b1, ovf: ovf_q};
    end else begin
      sts_len   = cur_len;
      sts_flags = '{ecrc: ecrc_err, malf: malformed, frame: 1'b0, ovf: new_ovf};
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      len_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      if (active) begin
        len_q <= len_d;
        ovf_q <= ovf_d;
      end
    end
  end

endmodule

// File: rtl/rxc_pkt_buf.sv
module rxc_pkt_buf #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              discard,
  input  logic              rd_pop,
  output logic              full_wr,
  output logic              full_base,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     cmt_ptr,
  output logic [PW-1:0]     rd_ptr
);

  // DEPTH must be a power of two of at least 2 so that pointers wrap cleanly.
  localparam logic [PW-1:0] CAP = PW'(DEPTH);
  localparam logic [PW-1:0] INC = PW'(1);

  logic [DATA_W-1:0] mem_q [DEPTH];

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] cmt_q, cmt_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [PW-1:0] base;
  logic          pop;

  always_comb begin
    base      = discard ? cmt_q : wr_q;
    wr_d      = wr_en ? base + INC : base;
    cmt_d     = commit ? wr_d : cmt_q;
    rd_valid  = (cmt_q != rd_q);
    pop       = rd_pop & rd_valid;
    rd_d      = pop ? rd_q + INC : rd_q;
    full_wr   = ((wr_q - rd_q) == CAP);
    full_base = ((cmt_q - rd_q) == CAP);
    rd_data   = mem_q[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[base[AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      wr_q  <= wr_d;
      cmt_q <= cmt_d;
      rd_q  <= rd_d;
    end
  end

  assign wr_ptr  = wr_q;
  assign cmt_ptr = cmt_q;
  assign rd_ptr  = rd_q;

endmodule

// File: rtl/rxc_status_reg.sv
module rxc_status_reg
  import rxc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len_in,
  input  rxc_flags_t       flags_in,
  output logic             valid,
  output logic [LEN_W-1:0] len_out,
  output rxc_flags_t       flags_out
);

  logic             valid_q;
  logic [LEN_W-1:0] len_q;
  rxc_flags_t       flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      flags_q <= RXC_NO_FAULT;
    end else begin
      valid_q <= fire;
      if (fire) begin
        len_q   <= len_in;
        flags_q <= flags_in;
      end
    end
  end

  assign valid     = valid_q;
  assign len_out   = len_q;
  assign flags_out = flags_q;

endmodule

// File: rtl/rxpkt_collector.sv
module rxpkt_collector
  import rxc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ecrc_err,
  input  logic              rx_malformed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              stat_valid,
  output logic [LEN_W-1:0]  stat_len,
  output logic              stat_ecrc,
  output logic              stat_malf,
  output logic              stat_frame,
  output logic              stat_ovf
);

  localparam int PW = $clog2(DEPTH) + 1;

  logic             rst_s;
  logic             wr_en, commit, discard;
  logic             full_wr, full_base;
  logic             sts_fire;
  logic [LEN_W-1:0] sts_len;
  rxc_flags_t       sts_flags;
  rxc_flags_t       stat_flags;
  logic [PW-1:0]    wr_ptr_w, cmt_ptr_w, rd_ptr_w;

  rxc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  rxc_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .sop       (rx_sop),
    .eop       (rx_eop),
    .ecrc_err  (rx_ecrc_err),
    .malformed (rx_malformed),
    .full_wr   (full_wr),
    .full_base (full_base),
    .wr_en     (wr_en),
    .commit    (commit),
    .discard   (discard),
    .sts_fire  (sts_fire),
    .sts_len   (sts_len),
    .sts_flags (sts_flags)
  );

  rxc_pkt_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_en     (wr_en),
    .wr_data   (rx_data),
    .commit    (commit),
    .discard   (discard),
    .rd_pop    (out_ready),
    .full_wr   (full_wr),
    .full_base (full_base),
    .rd_valid  (out_valid),
    .rd_data   (out_data),
    .wr_ptr    (wr_ptr_w),
    .cmt_ptr   (cmt_ptr_w),
    .rd_ptr    (rd_ptr_w)
  );

  rxc_status_reg #(.LEN_W(LEN_W)) u_sts (
    .clk       (clk),
    .rst_n     (rst_s),
    .fire      (sts_fire),
    .len_in    (sts_len),
    .flags_in  (sts_flags),
    .valid     (stat_valid),
    .len_out   (stat_len),
    .flags_out (stat_flags)
  );

  assign stat_ecrc  = stat_flags.ecrc;
  assign stat_malf  = stat_flags.malf;
  assign stat_frame = stat_flags.frame;
  assign stat_ovf   = stat_flags.ovf;

endmodule

// File: rtl/rxc_chk.sv
module rxc_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 10,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sop,
  input logic             rx_eop,
  input logic             stat_valid,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_ecrc,
  input logic             stat_malf,
  input logic             stat_frame,
  input logic             stat_ovf,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    cmt_ptr,
  input logic [PW-1:0]    rd_ptr
);

  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic any_fault;
  assign any_fault = stat_ecrc | stat_malf | stat_frame | stat_ovf;

  // R9: held words never exceed the buffer depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= CAP);

  // R11: the reader never reaches past the committed position
  p_pending_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(cmt_ptr - rd_ptr) <= PW'(wr_ptr - rd_ptr));

  // R10: a status always follows a strobe
  p_status_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(rx_sop || rx_eop));

  // R7: a framing status always follows a start strobe
  p_frame_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_frame) |-> $past(rx_sop));

  // R4: a faulty packet leaves the committed position where it was
  p_fault_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && any_fault) |-> (cmt_ptr == $past(cmt_ptr)));

  // R2: a clean packet advances the committed position by its length
  p_clean_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !any_fault) |-> (PW'(cmt_ptr - $past(cmt_ptr)) == PW'(stat_len)));

endmodule

bind rxpkt_collector rxc_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_sop     (rx_sop),
  .rx_eop     (rx_eop),
  .stat_valid (stat_valid),
  .stat_len   (stat_len),
  .stat_ecrc  (stat_ecrc),
  .stat_malf  (stat_malf),
  .stat_frame (stat_frame),
  .stat_ovf   (stat_ovf),
  .wr_ptr     (wr_ptr_w),
  .cmt_ptr    (cmt_ptr_w),
  .rd_ptr     (rd_ptr_w)
);

// File: tb/sim_rxpkt_collector.sv
module sim_rxpkt_collector;

  localparam int DW  = 16;
  localparam int DEP = 8;
  localparam int LW  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_sop, rx_eop, rx_ecrc_err, rx_malformed;
  logic [DW-1:0] rx_data;
  logic          out_valid, out_ready;
  logic [DW-1:0] out_data;
  logic          stat_valid;
  logic [LW-1:0] stat_len;
  logic          stat_ecrc, stat_malf, stat_frame, stat_ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rxpkt_collector #(.DATA_W(DW), .DEPTH(DEP), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .rx_ecrc_err(rx_ecrc_err), .rx_malformed(rx_malformed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_ecrc(stat_ecrc),
    .stat_malf(stat_malf), .stat_frame(stat_frame), .stat_ovf(stat_ovf)
  );

  function automatic logic [DW-1:0] word(input int tag, input int idx);
    return DW'((tag << 8) | idx);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
    rx_ecrc_err = 1'b0; rx_malformed = 1'b0;
  endtask

  task automatic beat(input logic s, input logic e, input logic [DW-1:0] d,
                      input logic ec, input logic ml);
    rx_sop = s; rx_eop = e; rx_data = d; rx_ecrc_err = ec; rx_malformed = ml;
    @(negedge clk);
  endtask

  // Whole packet; on return the status of its final beat is visible.
  task automatic send(input int len, input int tag, input logic ec_end,
                      input logic ml_end, input logic mid_err);
    for (int i = 0; i < len; i++) begin
      if (i == len - 1) beat(i == 0, 1'b1, word(tag, i), ec_end, ml_end);
      else              beat(i == 0, 1'b0, word(tag, i), mid_err, mid_err);
    end
    idle();
  endtask

  task automatic chk_status(input string req, input int len, input logic [3:0] fl);
    check({req, " stat_valid"}, int'(stat_valid), 1);
    check({req, " stat_len"}, int'(stat_len), len);
    check({req, " fault bits"}, int'({stat_ecrc, stat_malf, stat_frame, stat_ovf}), int'(fl));
  endtask

  task automatic drain(input string req, input int n, input int tag, input bit expect_empty);
    for (int k = 0; k < n; k++) begin
      check({req, " out_valid"}, int'(out_valid), 1);
      check({req, " out_data"}, int'(out_data), int'(word(tag, k)));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    if (expect_empty) check({req, " empty after drain"}, int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the run completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    out_ready = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 stat_valid in reset", int'(stat_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3: every clean length up to the depth
    for (int len = 1; len <= DEP; len++) begin
      send(len, len, 1'b0, 1'b0, 1'b0);
      chk_status("R3 clean", len, 4'b0000);
      @(negedge clk);
      check("R3 single-cycle pulse", int'(stat_valid), 0);
      drain("R2 order", len, len, 1'b1);
    end

    // R4 / R6: end-beat faults discard
    for (int len = 1; len <= 4; len++) begin
      send(len, 16 + len, 1'b1, 1'b0, 1'b0);
      chk_status("R4 crc", len, 4'b1000);
      check("R4 nothing stored", int'(out_valid), 0);
      send(len, 32 + len, 1'b0, 1'b1, 1'b0);
      chk_status("R6 length", len, 4'b0100);
      check("R6 nothing stored", int'(out_valid), 0);
      send(len, 48 + len, 1'b1, 1'b1, 1'b0);
      chk_status("R4 R6 both", len, 4'b1100);
      check("R4 R6 nothing stored", int'(out_valid), 0);
    end

    // R5: flags on earlier beats ignored
    send(4, 24, 1'b0, 1'b0, 1'b1);
    chk_status("R5 mid-beat flags", 4, 4'b0000);
    drain("R5 stored", 4, 24, 1'b1);

    // R11: pending words hidden
    beat(1'b1, 1'b0, word(25, 0), 1'b0, 1'b0);
    beat(1'b0, 1'b0, word(25, 1), 1'b0, 1'b0);
    check("R11 pending hidden", int'(out_valid), 0);
    beat(1'b0, 1'b1, word(25, 2), 1'b0, 1'b0);
    idle();
    chk_status("R11 commit", 3, 4'b0000);
    drain("R11 visible after commit", 3, 25, 1'b1);

    // R7: start inside an open packet
    beat(1'b1, 1'b0, word(32, 0), 1'b0, 1'b0);
    beat(1'b0, 1'b0, word(32, 1), 1'b0, 1'b0);
    beat(1'b1, 1'b0, word(33, 0), 1'b0, 1'b0);
    chk_status("R7 frame", 2, 4'b0010);
    beat(1'b0, 1'b0, word(33, 1), 1'b0, 1'b0);
    check("R7 one status only", int'(stat_valid), 0);
    beat(1'b0, 1'b1, word(33, 2), 1'b0, 1'b0);
    idle();
    chk_status("R7 new packet", 3, 4'b0000);
    drain("R7 only new words", 3, 33, 1'b1);

    // R8: start and end together inside an open packet
    beat(1'b1, 1'b0, word(34, 0), 1'b0, 1'b0);
    beat(1'b0, 1'b0, word(34, 1), 1'b0, 1'b0);
    beat(1'b0, 1'b0, word(34, 2), 1'b0, 1'b0);
    beat(1'b1, 1'b1, word(35, 0), 1'b0, 1'b0);
    idle();
    chk_status("R8 collision", 3, 4'b0010);
    check("R8 nothing stored", int'(out_valid), 0);
    @(negedge clk);
    check("R8 single status", int'(stat_valid), 0);
    send(2, 36, 1'b0, 1'b0, 1'b0);
    chk_status("R8 recovers", 2, 4'b0000);
    drain("R8 recovers", 2, 36, 1'b1);

    // R9: oversize packet into an empty buffer
    send(DEP + 2, 64, 1'b0, 1'b0, 1'b0);
    chk_status("R9 oversize", DEP + 2, 4'b0001);
    check("R9 nothing stored", int'(out_valid), 0);

    // R9: every prefill against every length
    for (int p = 1; p < DEP; p++) begin
      for (int len = 1; len <= DEP; len++) begin
        bit fit;
        fit = (p + len) <= DEP;
        send(p, 96, 1'b0, 1'b0, 1'b0);
        chk_status("R9 prefill", p, 4'b0000);
        send(len, 112, 1'b0, 1'b0, 1'b0);
        chk_status("R9 fill boundary", len, fit ? 4'b0000 : 4'b0001);
        drain("R9 prefill intact", p, 96, !fit);
        if (fit) drain("R9 fitted packet", len, 112, 1'b1);
      end
    end

    // R10: strobes outside any packet
    beat(1'b0, 1'b1, word(120, 0), 1'b1, 1'b1);
    check("R10 stray end no status", int'(stat_valid), 0);
    beat(1'b0, 1'b0, word(120, 1), 1'b0, 1'b0);
    check("R10 stray end no status", int'(stat_valid), 0);
    check("R10 nothing stored", int'(out_valid), 0);
    idle();
    @(negedge clk);
    check("R10 still idle", int'(stat_valid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule